// File: doc/BRIEF.md
# Power and Reset State Controller

This block sequences a small system-on-chip through three power states, Run, Halt and Standby, and turns three active-low reset pins into the chip's internal resets. Run clocks everything. Halt stops only the processor clock. Standby also drops the display enable and the main oscillator enable. A wake event, such as a key press, returns the chip from Halt or Standby to Run. Software moves the chip from Run into Halt or Standby with one-cycle request pulses. The low-frequency timebase enable stays on in every state.

The resets fall into two domains. The general domain covers most of the chip. The preserved domain holds the memory refresh and configuration settings and the real-time clock registers. A power-on reset is cold: it clears both domains at once and needs no handshake. A power-fail or user reset is warm. It first raises a self-refresh request to the external memory controller. It applies the general-domain reset only after the acknowledge arrives, or after a bounded timeout, and it leaves the preserved domain untouched. Every reset ends in Standby. A sticky status register records what caused each reset, and software clears its bits by writing ones.

Top module: `pwr_rst_ctrl`

## Requirements
- R1: During the cycle after `por_n` is sampled low, the outputs are: `gen_rst_n`=0, `keep_rst_n`=0, `sr_req`=0, `pwr_state`=Standby and `rst_status`=5'b00001. The cycle after `por_n` is sampled high again, both domain resets read 1.
- R2: The `pwr_state` encoding is Run=2'b00, Halt=2'b01, Standby=2'b10. In Run, `cpu_clk_en`, `osc_main_en` and `lcd_en` are all 1. `lf_clk_en` is 1 in every state and during every reset.
- R3: In Halt, `cpu_clk_en`=0 while `osc_main_en`=1 and `lcd_en`=1. A `wake_evt` sampled in Halt moves the state to Run in the next cycle.
- R4: In Standby, `cpu_clk_en`, `osc_main_en` and `lcd_en` are all 0. A `wake_evt` sampled in Standby moves the state to Run in the next cycle.
- R5: In Run, `req_stby` leads to Standby and `req_halt` leads to Halt. When both are high, Standby wins. Both requests are ignored in Halt, in Standby, and while a warm reset sequence is in progress.
- R6: When `pfail_n` or `urst_n` is sampled low while no sequence is active, `sr_req` reads 1 in the next cycle. `gen_rst_n` stays 1 until the acknowledge or the timeout, and `keep_rst_n` stays 1 for the whole warm sequence.
- R7: When `sr_ack` is sampled high while `sr_req` is 1 and the general reset is not yet applied, `gen_rst_n` reads 0 in the next cycle. One cycle later, `pwr_state` is Standby.
- R8: Without an acknowledge, `gen_rst_n` stays 1 for exactly SREF_TMO (default 16) cycles with `sr_req`=1, then drops. Status bit 4 (refresh timeout) is set at the same edge.
- R9: The general reset holds while either warm pin is low. `gen_rst_n` returns to 1 and `sr_req` to 0 in the cycle after both pins are sampled high, and the state is then Standby.
- R10: Status bit 1 (power-fail) and bit 2 (user) set while their pins are sampled low. Bit 3 (warm reset applied) sets one cycle after the general reset is applied.
- R11: Status bits are sticky. A cycle with `sts_clr_we`=1 clears every bit whose `sts_clr` bit is 1. A bit that is being set in the same cycle stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running controller clock |
| por_n | input | 1 | Synchronized power-on reset, active low |
| pfail_n | input | 1 | Synchronized power-fail reset, active low |
| urst_n | input | 1 | Synchronized user reset, active low |
| wake_evt | input | 1 | Wake event from Halt or Standby |
| req_halt | input | 1 | Software request to enter Halt |
| req_stby | input | 1 | Software request to enter Standby |
| sr_ack | input | 1 | Self-refresh acknowledge from the memory controller |
| sts_clr_we | input | 1 | Status clear strobe |
| sts_clr | input | 5 | Write-one-to-clear mask for the status |
| cpu_clk_en | output | 1 | Processor clock enable |
| osc_main_en | output | 1 | Main oscillator enable |
| lcd_en | output | 1 | Display enable |
| lf_clk_en | output | 1 | Low-frequency timebase enable |
| gen_rst_n | output | 1 | General domain reset, active low |
| keep_rst_n | output | 1 | Preserved domain reset, active low |
| sr_req | output | 1 | Self-refresh request to external memory |
| pwr_state | output | 2 | Current power state |
| rst_status | output | 5 | Sticky reset cause status |

## Verification
Two events can land on the same status bit in the same cycle: software clearing the bit, and a warm reset pin setting it. The bench provokes this by lowering `pfail_n` in the very cycle it writes an all-ones clear mask. It then expects only the power-fail bit to survive, while the earlier timeout and warm-applied bits are cleared. A second overlap is a software Halt request arriving while the self-refresh handshake is pending. There the request must be ignored, and the state must stay Run until the general reset forces Standby.

// File: rtl/pwr_rst_pkg.sv
// Package: shared encodings for the power and reset controller.
// Assumes: state values are visible at the top ports, so they are fixed.
package pwr_rst_pkg;

    localparam int STS_W = 5;

    // Status bit positions
    localparam int STS_COLD = 0;
    localparam int STS_PF   = 1;
    localparam int STS_USR  = 2;
    localparam int STS_WARM = 3;
    localparam int STS_TMO  = 4;

    typedef enum logic [1:0] {
        PS_RUN  = 2'b00,
        PS_HALT = 2'b01,
        PS_STBY = 2'b10
    } pstate_e;

    typedef enum logic [1:0] {
        RS_IDLE = 2'b00,
        RS_SREF = 2'b01,
        RS_HOLD = 2'b10
    } rseq_e;

endpackage

// File: rtl/pwr_rst_seq.sv
// Module: warm/cold reset sequencer.
// Function: a cold reset (rst_n low) clears both domains. A warm pin
//   first raises a self-refresh request. The general reset is applied
//   once the acknowledge arrives or SREF_TMO cycles pass, then held
//   until both warm pins are high.
// Assumes: all pins are already synchronized to clk. rst_n is the
//   power-on pin, used as a synchronous reset.
module pwr_rst_seq
    import pwr_rst_pkg::*;
#(
    parameter int SREF_TMO = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pfail_n,
    input  logic urst_n,
    input  logic sr_ack,
    output logic busy,
    output logic hold,
    output logic sr_req,
    output logic tmo_hit,
    output logic gen_rst_n,
    output logic keep_rst_n
);

    localparam int CNT_W = $clog2(SREF_TMO + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SREF_TMO - 1);

    rseq_e            rs_q, rs_d;
    logic [CNT_W-1:0] cnt_q;
    logic             cold_done_q;
    logic             warm_low;

    assign warm_low = !pfail_n || !urst_n;
    assign tmo_hit  = (rs_q == RS_SREF) && !sr_ack && (cnt_q == CNT_LAST);

    // Next sequencer state
    always_comb begin
        rs_d = rs_q;
        unique case (rs_q)
            RS_IDLE: if (warm_low) rs_d = RS_SREF;
            RS_SREF: if (sr_ack || cnt_q == CNT_LAST) rs_d = RS_HOLD;
            RS_HOLD: if (!warm_low) rs_d = RS_IDLE;
            default: rs_d = RS_IDLE;
        endcase
    end

    // Sequencer state register
    always_ff @(posedge clk) begin
        if (!rst_n) rs_q <= RS_IDLE;
        else        rs_q <= rs_d;
    end

    // Handshake timeout counter, restarts each time a sequence begins
    always_ff @(posedge clk) begin
        if (!rst_n || rs_q != RS_SREF) cnt_q <= '0;
        else                           cnt_q <= cnt_q + 1'b1;
    end

    // Marks that the cold reset has been released
    always_ff @(posedge clk) begin
        if (!rst_n) cold_done_q <= 1'b0;
        else        cold_done_q <= 1'b1;
    end

    assign busy       = (rs_q != RS_IDLE);
    assign hold       = (rs_q == RS_HOLD);
    assign sr_req     = busy;
    assign gen_rst_n  = cold_done_q && !hold;
    assign keep_rst_n = cold_done_q;

    AST_NO_SKIP_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_q == RS_IDLE) |=> (rs_q != RS_HOLD)); // R6
    AST_TMO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_q == RS_SREF) |-> (cnt_q <= CNT_LAST)); // R8
    AST_ACK_APPLIES: assert property (@(posedge clk) disable iff (!rst_n)
        ((rs_q == RS_SREF) && sr_ack) |=> !gen_rst_n); // R7

endmodule

// File: rtl/pwr_state_fsm.sv
// Module: Run / Halt / Standby state machine.
// Function: software requests leave Run, a wake event returns to Run,
//   and a held general reset forces Standby.
// Assumes: requests are single-cycle pulses. rst_n is the cold reset.
module pwr_state_fsm
    import pwr_rst_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    force_stby,
    input  logic    inhibit,
    input  logic    wake_evt,
    input  logic    req_halt,
    input  logic    req_stby,
    output pstate_e st_q
);

    pstate_e st_d;

    // Next power state; the forced entry to Standby has top priority
    always_comb begin
        st_d = st_q;
        if (force_stby) begin
            st_d = PS_STBY;
        end else if (!inhibit) begin
            unique case (st_q)
                PS_RUN: begin
                    if (req_stby)      st_d = PS_STBY;
                    else if (req_halt) st_d = PS_HALT;
                end
                PS_HALT, PS_STBY: if (wake_evt) st_d = PS_RUN;
                default: st_d = PS_STBY;
            endcase
        end
    end

    // State register; every reset lands in Standby
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= PS_STBY;
        else        st_q <= st_d;
    end

    AST_HALT_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PS_HALT && wake_evt && !force_stby && !inhibit) |=> (st_q == PS_RUN)); // R3
    AST_STBY_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PS_STBY && wake_evt && !force_stby && !inhibit) |=> (st_q == PS_RUN)); // R4
    AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (inhibit && !force_stby) |=> $stable(st_q)); // R5

endmodule

// File: rtl/rst_cause_reg.sv
// Module: sticky reset cause status.
// Function: each bit sets on its event and clears by a write of one.
//   A set in the same cycle as a clear wins.
// Assumes: rst_n is the cold reset; it leaves only the cold bit set.
module rst_cause_reg
    import pwr_rst_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [STS_W-1:0] set_vec,
    input  logic             clr_we,
    input  logic [STS_W-1:0] clr_vec,
    output logic [STS_W-1:0] sts_q
);

    logic [STS_W-1:0] clr_mask;

    assign clr_mask = clr_we ? clr_vec : '0;

    for (genvar b = 0; b < STS_W; b++) begin : g_bit
        // Per-bit sticky flag with set-over-clear priority
        always_ff @(posedge clk) begin
            if (!rst_n)          sts_q[b] <= (b == STS_COLD);
            else if (set_vec[b]) sts_q[b] <= 1'b1;
            else if (clr_mask[b]) sts_q[b] <= 1'b0;
        end
    end

    AST_COLD_CAUSE: assert property (@(posedge clk)
        !rst_n |=> (sts_q == STS_W'(1))); // R1
    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((sts_q & $past(sts_q & ~clr_mask)) == $past(sts_q & ~clr_mask))); // R11
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((sts_q & $past(set_vec)) == $past(set_vec))); // R11

endmodule

// File: rtl/pwr_rst_ctrl.sv
// Module: power and reset state controller, top level.
// Function: ties the reset sequencer, the power state machine and the
//   cause status together, and decodes the clock and oscillator enables.
// Assumes: the reset pins are synchronized to clk, which keeps running
//   in every state.
module pwr_rst_ctrl
    import pwr_rst_pkg::*;
#(
    parameter int SREF_TMO = 16
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       pfail_n,
    input  logic       urst_n,
    input  logic       wake_evt,
    input  logic       req_halt,
    input  logic       req_stby,
    input  logic       sr_ack,
    input  logic       sts_clr_we,
    input  logic [4:0] sts_clr,
    output logic       cpu_clk_en,
    output logic       osc_main_en,
    output logic       lcd_en,
    output logic       lf_clk_en,
    output logic       gen_rst_n,
    output logic       keep_rst_n,
    output logic       sr_req,
    output logic [1:0] pwr_state,
    output logic [4:0] rst_status
);

    logic             busy, hold, tmo_hit;
    pstate_e          st;
    logic [STS_W-1:0] set_vec;

    pwr_rst_seq #(.SREF_TMO(SREF_TMO)) u_seq (
        .clk        (clk),
        .rst_n      (por_n),
        .pfail_n    (pfail_n),
        .urst_n     (urst_n),
        .sr_ack     (sr_ack),
        .busy       (busy),
        .hold       (hold),
        .sr_req     (sr_req),
        .tmo_hit    (tmo_hit),
        .gen_rst_n  (gen_rst_n),
        .keep_rst_n (keep_rst_n)
    );

    pwr_state_fsm u_fsm (
        .clk        (clk),
        .rst_n      (por_n),
        .force_stby (hold),
        .inhibit    (busy),
        .wake_evt   (wake_evt),
        .req_halt   (req_halt),
        .req_stby   (req_stby),
        .st_q       (st)
    );

    // Events that set status bits this cycle
    always_comb begin
        set_vec           = '0;
        set_vec[STS_PF]   = !pfail_n;
        set_vec[STS_USR]  = !urst_n;
        set_vec[STS_WARM] = hold;
        set_vec[STS_TMO]  = tmo_hit;
    end

    rst_cause_reg u_sts (
        .clk     (clk),
        .rst_n   (por_n),
        .set_vec (set_vec),
        .clr_we  (sts_clr_we),
        .clr_vec (sts_clr),
        .sts_q   (rst_status)
    );

    assign pwr_state   = st;
    assign cpu_clk_en  = (st == PS_RUN);
    assign osc_main_en = (st != PS_STBY);
    assign lcd_en      = (st != PS_STBY);
    assign lf_clk_en   = 1'b1;

    AST_CPU_NEEDS_OSC: assert property (@(posedge clk) disable iff (!por_n)
        cpu_clk_en |-> (osc_main_en && lcd_en)); // R2
    AST_WARM_SPARES_KEEP: assert property (@(posedge clk) disable iff (!por_n)
        sr_req |-> keep_rst_n); // R6
    AST_GEN_ONLY_WITH_SREF: assert property (@(posedge clk) disable iff (!por_n)
        (keep_rst_n && !gen_rst_n) |-> sr_req); // R9

endmodule

// File: tb/tb_pwr_rst_ctrl.sv
module tb_pwr_rst_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int TMO = 16;

    logic       clk = 1'b0;
    logic       por_n = 1'b0, pfail_n = 1'b1, urst_n = 1'b1;
    logic       wake_evt = 1'b0, req_halt = 1'b0, req_stby = 1'b0, sr_ack = 1'b0;
    logic       sts_clr_we = 1'b0;
    logic [4:0] sts_clr = '0;
    logic       cpu_clk_en, osc_main_en, lcd_en, lf_clk_en;
    logic       gen_rst_n, keep_rst_n, sr_req;
    logic [1:0] pwr_state;
    logic [4:0] rst_status;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwr_rst_ctrl #(.SREF_TMO(TMO)) dut (
        .clk(clk), .por_n(por_n), .pfail_n(pfail_n), .urst_n(urst_n),
        .wake_evt(wake_evt), .req_halt(req_halt), .req_stby(req_stby),
        .sr_ack(sr_ack), .sts_clr_we(sts_clr_we), .sts_clr(sts_clr),
        .cpu_clk_en(cpu_clk_en), .osc_main_en(osc_main_en), .lcd_en(lcd_en),
        .lf_clk_en(lf_clk_en), .gen_rst_n(gen_rst_n), .keep_rst_n(keep_rst_n),
        .sr_req(sr_req), .pwr_state(pwr_state), .rst_status(rst_status)
    );

    // Vector: {wake, halt, stby, expected state[1:0]}
    localparam logic [4:0] VEC [10] = '{
        {3'b100, 2'b00},   // Standby + wake -> Run
        {3'b010, 2'b01},   // Run + halt -> Halt
        {3'b001, 2'b01},   // Halt ignores standby request
        {3'b100, 2'b00},   // Halt + wake -> Run
        {3'b011, 2'b10},   // both requests -> Standby
        {3'b010, 2'b10},   // Standby ignores halt
        {3'b000, 2'b10},   // idle cycle
        {3'b100, 2'b00},   // wake -> Run
        {3'b001, 2'b10},   // Run + standby -> Standby
        {3'b100, 2'b00}    // wake -> Run
    };

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk_enables(input string req, input logic [1:0] st);
        chk(req, {6'b0, pwr_state}, {6'b0, st});
        chk(req, {4'b0, cpu_clk_en, osc_main_en, lcd_en, lf_clk_en},
            {4'b0, st == 2'b00, st != 2'b10, st != 2'b10, 1'b1});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk + 1 - n_bad, n_chk + 1);
        $finish;
    end

    initial begin
        // R1: cold reset state
        repeat (3) step();
        chk("R1 gen", {7'b0, gen_rst_n}, 8'd0);
        chk("R1 keep", {7'b0, keep_rst_n}, 8'd0);
        chk("R1 sreq", {7'b0, sr_req}, 8'd0);
        chk("R1 status", {3'b0, rst_status}, 8'h01);
        chk_enables("R1 R4 standby", 2'b10);
        por_n = 1'b1;
        step();
        chk("R1 released", {6'b0, gen_rst_n, keep_rst_n}, 8'h03);
        // R11: write-one clears the cold bit
        sts_clr_we = 1'b1; sts_clr = 5'b00001;
        step();
        sts_clr_we = 1'b0; sts_clr = '0;
        chk("R11 clear", {3'b0, rst_status}, 8'h00);

        // R2 R3 R4 R5: vector walk of the power states
        for (int i = 0; i < 10; i++) begin
            {wake_evt, req_halt, req_stby} = VEC[i][4:2];
            step();
            {wake_evt, req_halt, req_stby} = 3'b000;
            chk_enables($sformatf("R2 R3 R4 R5 vec%0d", i), VEC[i][1:0]);
        end

        // R6 R7 R9 R10: user reset with acknowledge, starting in Run
        urst_n = 1'b0;
        step();
        chk("R6 sreq", {7'b0, sr_req}, 8'd1);
        chk("R6 gen held off", {6'b0, gen_rst_n, keep_rst_n}, 8'h03);
        req_halt = 1'b1;
        step();
        req_halt = 1'b0;
        chk("R5 halt ignored in sequence", {6'b0, pwr_state}, 8'h00);
        sr_ack = 1'b1;
        step();
        sr_ack = 1'b0;
        chk("R7 gen applied", {6'b0, gen_rst_n, keep_rst_n}, 8'h01);
        step();
        chk_enables("R7 standby", 2'b10);
        chk("R10 user+warm", {3'b0, rst_status}, 8'h0C);
        urst_n = 1'b1;
        step();
        chk("R9 release", {5'b0, gen_rst_n, keep_rst_n, sr_req}, 8'h06);
        chk("R9 state", {6'b0, pwr_state}, 8'h02);

        // R8: power-fail reset with no acknowledge
        sts_clr_we = 1'b1; sts_clr = 5'b11111;
        step();
        sts_clr_we = 1'b0; sts_clr = '0;
        wake_evt = 1'b1;
        step();
        wake_evt = 1'b0;
        pfail_n = 1'b0;
        step();
        repeat (TMO - 1) step();
        chk("R8 before timeout", {6'b0, gen_rst_n, sr_req}, 8'h03);
        step();
        chk("R8 at timeout", {6'b0, gen_rst_n, sr_req}, 8'h01);
        step();
        chk("R8 R10 status", {3'b0, rst_status}, 8'h1A);
        pfail_n = 1'b1;
        step();
        chk("R9 release pf", {7'b0, gen_rst_n}, 8'd1);

        // R11: clear and set collide on the power-fail bit
        pfail_n = 1'b0; sts_clr_we = 1'b1; sts_clr = 5'b11111;
        step();
        sts_clr_we = 1'b0; sts_clr = '0;
        chk("R11 set wins", {3'b0, rst_status}, 8'h02);
        sr_ack = 1'b1;
        step();
        sr_ack = 1'b0; pfail_n = 1'b1;
        step();
        step();
        chk("R9 back idle", {6'b0, gen_rst_n, sr_req}, 8'h02);

        // R1: cold reset from Run
        wake_evt = 1'b1;
        step();
        wake_evt = 1'b0;
        chk_enables("R4 wake", 2'b00);
        por_n = 1'b0;
        step();
        chk("R1 cold from run", {1'b0, rst_status, gen_rst_n, keep_rst_n}, {1'b0, 5'h01, 2'b00});
        chk_enables("R1 R2 cold state", 2'b10);
        por_n = 1'b1;
        step();

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule